// File: doc/BRIEF.md
# Ordered Three-Button Sequence Detector

This block is a clocked Moore state machine that watches three push-button inputs, A, B and C, for one particular order of presses: A first, then C, then B. Each press reaches the block as a single-cycle pulse that is already synchronous to the clock and free of bounce. Two outputs report progress. `match_o` goes high once the full ordered sequence has been entered. `ready_o` goes high while the machine sits in its start state, waiting for a new attempt to begin.

There are four states. START (`ready_o`=1) waits for an opening A. SAW_A has seen A. SAW_AC has seen A then C. MATCH (`match_o`=1) holds after the closing B. The named transitions are:
- hold: no button pressed, from any state back into the same state.
- open: a lone A from any state goes to SAW_A.
- advance: a lone C in SAW_A goes to SAW_AC.
- complete: a lone B in SAW_AC goes to MATCH.
- abort: any other press goes to START. This covers a wrong single button and any cycle with two or three buttons pressed.

Every state decodes every input pattern to exactly one next state, so the branching is complete and unambiguous. The state codes put each output on a bit of its own, and most transitions change only one bit.

Top module: `seq_order_detector`

## Requirements
- R1: A synchronous reset (`rst`=1 at a rising clock edge) puts the machine in START: after that edge `ready_o`=1 and `match_o`=0.
- R2: In a cycle with no button pressed the state holds, so neither output changes at the following edge.
- R3: A lone A press (`btn_a`=1, `btn_b`=0, `btn_c`=0) from any state moves to SAW_A: after the edge `ready_o`=0 and `match_o`=0.
- R4: Lone presses A, C, B in that order, with any number of idle cycles between them, give `match_o`=1 and `ready_o`=0 from the edge that samples the B press.
- R5: After a match, `match_o` stays 1 until the next press. That press clears it. A lone A counts as the first step of a new attempt (SAW_A); any other press returns to START.
- R6: A lone press of the wrong button goes to START (`ready_o`=1). This covers B or C in START, B or C in SAW_A other than the expected C, and C in SAW_AC.
- R7: A cycle with two or three buttons pressed at once goes to START, including patterns that contain A.
- R8: `match_o` and `ready_o` are never high together, and each is driven to a defined level in every state.
- R9: A button press in a cycle where `rst` is high has no effect: after that edge the machine is in START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state loads on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| btn_a | input | 1 | Single-cycle press pulse of button A (first in the order) |
| btn_b | input | 1 | Single-cycle press pulse of button B (last in the order) |
| btn_c | input | 1 | Single-cycle press pulse of button C (second in the order) |
| match_o | output | 1 | High while in MATCH |
| ready_o | output | 1 | High while in START |

## Verification
The properties assume that each button input is a clean pulse, sampled and stable around the rising edge, and that a press lasting one cycle means one press. They also assume that reset is the only way back to START apart from the abort transitions. The bench changes inputs only on falling edges and holds each press for exactly one cycle, with idle cycles where needed. Simultaneous presses are made on purpose, by driving several buttons in the same single cycle, so that the abort path is covered without ever presenting a long or glitchy pulse.

// File: rtl/seq_order_pkg.sv
package seq_order_pkg;

    localparam int STATE_W   = 3;
    localparam int READY_BIT = 0;
    localparam int MATCH_BIT = 2;
    localparam int BTN_N     = 3;

    // bit 0 carries ready, bit 2 carries match; neighbour codes differ by one bit
    typedef enum logic [STATE_W-1:0] {
        ST_START  = 3'b001,
        ST_SAW_A  = 3'b000,
        ST_SAW_AC = 3'b010,
        ST_MATCH  = 3'b110
    } state_e;

    typedef enum logic [2:0] {
        PR_NONE,
        PR_A,
        PR_B,
        PR_C,
        PR_MULTI
    } press_e;

    localparam state_e RESET_STATE = ST_START;

endpackage

// File: rtl/seq_press_classify.sv
module seq_press_classify
    import seq_order_pkg::*;
(
    input  logic   btn_a,
    input  logic   btn_b,
    input  logic   btn_c,
    output press_e cls
);

    logic [BTN_N-1:0] vec;

    always_comb begin
        vec = {btn_a, btn_b, btn_c};
        unique case (vec)
            3'b000:  cls = PR_NONE;
            3'b100:  cls = PR_A;
            3'b010:  cls = PR_B;
            3'b001:  cls = PR_C;
            default: cls = PR_MULTI;
        endcase
    end

endmodule

// File: rtl/seq_next_state.sv
module seq_next_state
    import seq_order_pkg::*;
(
    input  state_e cur,
    input  press_e cls,
    output state_e nxt
);

    always_comb begin
        nxt = RESET_STATE;
        unique case (cur)
            ST_START: begin
                unique case (cls)
                    PR_NONE: nxt = ST_START;
                    PR_A:    nxt = ST_SAW_A;
                    default: nxt = ST_START;
                endcase
            end
            ST_SAW_A: begin
                unique case (cls)
                    PR_NONE: nxt = ST_SAW_A;
                    PR_A:    nxt = ST_SAW_A;
                    PR_C:    nxt = ST_SAW_AC;
                    default: nxt = ST_START;
                endcase
            end
            ST_SAW_AC: begin
                unique case (cls)
                    PR_NONE: nxt = ST_SAW_AC;
                    PR_A:    nxt = ST_SAW_A;
                    PR_B:    nxt = ST_MATCH;
                    default: nxt = ST_START;
                endcase
            end
            ST_MATCH: begin
                unique case (cls)
                    PR_NONE: nxt = ST_MATCH;
                    PR_A:    nxt = ST_SAW_A;
                    default: nxt = ST_START;
                endcase
            end
            default: nxt = RESET_STATE;
        endcase
    end

endmodule

// File: rtl/seq_state_reg.sv
module seq_state_reg
    import seq_order_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_e nxt,
    output state_e cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= RESET_STATE;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/seq_order_detector.sv
module seq_order_detector
    import seq_order_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic btn_a,
    input  logic btn_b,
    input  logic btn_c,
    output logic match_o,
    output logic ready_o
);

    press_e cls;
    state_e cur;
    state_e nxt;

    seq_press_classify i_classify (
        .btn_a (btn_a),
        .btn_b (btn_b),
        .btn_c (btn_c),
        .cls   (cls)
    );

    seq_next_state i_next (
        .cur (cur),
        .cls (cls),
        .nxt (nxt)
    );

    seq_state_reg i_reg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .cur (cur)
    );

    // outputs are plain state bits, no decode
    always_comb begin
        match_o = cur[MATCH_BIT];
        ready_o = cur[READY_BIT];
    end

endmodule

// File: rtl/seq_order_checker.sv
module seq_order_checker (
    input logic clk,
    input logic rst,
    input logic btn_a,
    input logic btn_b,
    input logic btn_c,
    input logic match_o,
    input logic ready_o
);

    p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(match_o && ready_o));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!btn_a && !btn_b && !btn_c) |=> ($stable(match_o) && $stable(ready_o)));

    p_lone_a_r3: assert property (@(posedge clk) disable iff (rst)
        (btn_a && !btn_b && !btn_c) |=> (!match_o && !ready_o));

    p_multi_abort_r7: assert property (@(posedge clk) disable iff (rst)
        ($countones({btn_a, btn_b, btn_c}) > 1) |=> (ready_o && !match_o));

    p_match_on_b_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(match_o) |-> $past(btn_b && !btn_a && !btn_c));

    p_match_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (match_o && (btn_a || btn_b || btn_c)) |=> !match_o);

endmodule

bind seq_order_detector seq_order_checker i_seq_order_checker (.*);

// File: tb/test_seq_order_detector.sv
module test_seq_order_detector;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_a = 1'b0;
    logic btn_b = 1'b0;
    logic btn_c = 1'b0;
    logic match_o;
    logic ready_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_order_detector i_seq_order_detector (
        .clk     (clk),
        .rst     (rst),
        .btn_a   (btn_a),
        .btn_b   (btn_b),
        .btn_c   (btn_c),
        .match_o (match_o),
        .ready_o (ready_o)
    );

    task automatic chk(input string req, input logic exp_m, input logic exp_r);
        checks++;
        if (match_o !== exp_m || ready_o !== exp_r) begin
            failures++;
            $display("FAIL %s: match/ready actual=%b%b expected=%b%b",
                     req, match_o, ready_o, exp_m, exp_r);
        end
    endtask

    task automatic chk_excl();
        checks++;
        if (match_o === 1'b1 && ready_o === 1'b1) begin
            failures++;
            $display("FAIL R8: match/ready actual=11 expected=not both high");
        end
    endtask

    // drive one cycle of buttons on a falling edge; result visible at next falling edge
    task automatic press(input logic a, input logic b, input logic c);
        @(negedge clk);
        btn_a = a; btn_b = b; btn_c = c;
        @(negedge clk);
        btn_a = 1'b0; btn_b = 1'b0; btn_c = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic a, input logic b, input logic c);
        @(negedge clk);
        rst = 1'b1; btn_a = a; btn_b = b; btn_c = c;
        @(negedge clk);
        rst = 1'b0; btn_a = 1'b0; btn_b = 1'b0; btn_c = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b0, 1'b0);
        chk("R1 reset state", 1'b0, 1'b1);
        idle(3);
        chk("R2 idle in start", 1'b0, 1'b1);
    endtask

    task automatic t_basic_match();
        press(1, 0, 0);
        chk("R3 lone A from start", 1'b0, 1'b0);
        idle(4);
        chk("R2 hold in saw_a", 1'b0, 1'b0);
        press(0, 0, 1);
        chk("R4 C after A", 1'b0, 1'b0);
        idle(2);
        press(0, 1, 0);
        chk("R4 match after A C B", 1'b1, 1'b0);
        chk_excl();
        idle(5);
        chk("R5 match held while idle", 1'b1, 1'b0);
        press(0, 0, 1);
        chk("R5 non-A press clears match", 1'b0, 1'b1);
    endtask

    task automatic t_rematch_with_a();
        press(1, 0, 0); press(0, 0, 1); press(0, 1, 0);
        chk("R4 second match", 1'b1, 1'b0);
        press(1, 0, 0);
        chk("R5 A after match is first step", 1'b0, 1'b0);
        press(0, 0, 1); press(0, 1, 0);
        chk("R5 A counted, match again", 1'b1, 1'b0);
        press(0, 1, 0);
        chk("R5 B after match to start", 1'b0, 1'b1);
    endtask

    task automatic t_wrong_button();
        press(0, 0, 1);
        chk("R6 C in start", 1'b0, 1'b1);
        press(0, 1, 0);
        chk("R6 B in start", 1'b0, 1'b1);
        press(1, 0, 0); press(0, 1, 0);
        chk("R6 B in saw_a", 1'b0, 1'b1);
        press(1, 0, 0); press(0, 0, 1); press(0, 0, 1);
        chk("R6 C in saw_ac", 1'b0, 1'b1);
        press(1, 0, 0); press(1, 0, 0);
        chk("R3 A in saw_a", 1'b0, 1'b0);
        press(0, 0, 1); press(1, 0, 0);
        chk("R3 A in saw_ac", 1'b0, 1'b0);
        press(0, 0, 1); press(0, 1, 0);
        chk("R4 match after restart", 1'b1, 1'b0);
    endtask

    task automatic t_multi_press();
        press(1, 0, 0); press(1, 0, 1);
        chk("R7 A+C in saw_a", 1'b0, 1'b1);
        press(1, 0, 0); press(0, 0, 1); press(1, 1, 0);
        chk("R7 A+B in saw_ac", 1'b0, 1'b1);
        press(1, 1, 1);
        chk("R7 all three in start", 1'b0, 1'b1);
        press(1, 0, 0); press(0, 0, 1); press(0, 1, 0);
        press(1, 0, 1);
        chk("R7 A+C in match", 1'b0, 1'b1);
        chk_excl();
    endtask

    task automatic t_press_during_reset();
        press(1, 0, 0);
        do_reset(0, 0, 1);
        chk("R9 C during reset ignored", 1'b0, 1'b1);
        do_reset(1, 0, 0);
        chk("R9 A during reset ignored", 1'b0, 1'b1);
        press(1, 0, 0); press(0, 0, 1);
        do_reset(0, 1, 0);
        chk("R9 B during reset ignored", 1'b0, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_basic_match();
        t_rematch_with_a();
        t_wrong_button();
        t_multi_press();
        t_press_during_reset();
        idle(2);
        finish_run();
    end

endmodule